// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block adds or subtracts two operands at either byte (8-bit) or word (16-bit) width. It returns the result combinationally. From the same operation it derives six status flags: carry or borrow, signed overflow, sign, zero, nibble carry and parity. A registered 16-bit flags word holds these six flags at fixed positions, together with three control flags: direction, interrupt enable and trap.

The flags word changes on a rising clock edge only, and only when one of three things is requested. A status update (`wrEn`) writes the six arithmetic flags from the current operation. A full-word load (`loadEn`) replaces the whole register. Per-flag set and clear strobes change the three control flags. Arithmetic never modifies the control flags. The status flags keep their value whenever no update or load is requested.

Top module: `aluFlagUnit`

## Requirements
- R1: `result` equals the low 8 bits of the operation zero-extended to 16 bits when `wordMode`=0, and the full 16-bit value when `wordMode`=1. Operand bits above the selected width have no effect.
- R2: Subtraction (`opSub`=1) adds the inverted subtrahend plus one and discards the final carry out; a byte 53 minus 42 gives 11.
- R3: The carry flag (bit 0) holds the carry out of the most significant bit of the selected width for addition, and holds a borrow (1 when the unsigned minuend is smaller than the subtrahend) for subtraction.
- R4: The overflow flag (bit 11) is 1 when the signed result does not fit in the selected width.
- R5: The sign flag (bit 7) copies the most significant bit of the selected width of the result; the zero flag (bit 6) is 1 exactly when that result is all zeros.
- R6: The nibble carry flag (bit 4) is the carry from bit 3 into bit 4 for addition, and the borrow out of the low nibble for subtraction.
- R7: The parity flag (bit 2) is 1 when the low 8 bits of the result contain an even number of ones, in either width.
- R8: The flags word holds overflow at bit 11, direction at bit 10, interrupt enable at bit 9, trap at bit 8, sign 7, zero 6, nibble carry 4, parity 2 and carry 0. Bits 15:12, 5, 3 and 1 always read 0, and reset clears the whole word.
- R9: With `loadEn`=1 the next flags word is `loadValue` with the unused bits forced to 0. The load takes priority over `wrEn`, `ctlSet` and `ctlClr` in the same cycle.
- R10: `ctlSet[i]` sets and `ctlClr[i]` clears one control flag, with index 0 = trap, 1 = interrupt enable and 2 = direction. Set wins when both strobes are given for the same flag.
- R11: Arithmetic updates never change the control flags. Without `wrEn` or `loadEn`, the status flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 16 | First operand (minuend) |
| opB | input | 16 | Second operand (subtrahend) |
| opSub | input | 1 | 0 add, 1 subtract |
| wordMode | input | 1 | 0 byte width, 1 word width |
| wrEn | input | 1 | Write status flags from the current operation |
| loadEn | input | 1 | Load the whole flags word |
| loadValue | input | 16 | Value for the full-word load |
| ctlSet | input | 3 | Per-flag set: [0] trap, [1] interrupt enable, [2] direction |
| ctlClr | input | 3 | Per-flag clear, same indexing |
| result | output | 16 | Combinational sum or difference |
| flags | output | 16 | Registered flags word |

## Verification
`result` is combinational and is due in the same cycle as its operands. The bench drives operands on the falling edge and samples `result` a few nanoseconds later, before the next rising edge. The flags word sits behind one register, so each update, load or set/clear is due one rising edge after the request. The bench samples it at the following falling edge and compares it with a shadow word that it updates by the requirement rules. Hold cases apply new operands with all strobes low and check that the flags word does not move at that edge.

// File: rtl/flagPkg.sv
package flagPkg;
  localparam int FLAG_W   = 16;
  localparam int CF_B     = 0;
  localparam int PF_B     = 2;
  localparam int AF_B     = 4;
  localparam int ZF_B     = 6;
  localparam int SF_B     = 7;
  localparam int CTL_BASE = 8;   // trap 8, interrupt enable 9, direction 10
  localparam int CTL_N    = 3;
  localparam int OF_B     = 11;
  localparam logic [FLAG_W-1:0] STATUS_MASK = 16'h08D5;
  localparam logic [FLAG_W-1:0] CTL_MASK    = 16'h0700;
  localparam logic [FLAG_W-1:0] USED_MASK   = STATUS_MASK | CTL_MASK;

  typedef struct packed {
    logic             loadAll;
    logic             updStatus;
    logic [CTL_N-1:0] setCtl;
    logic [CTL_N-1:0] clrCtl;
  } strobeT;
endpackage

// File: rtl/flagAdder.sv
module flagAdder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             opSub,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             auxOut,
  output logic             ovfOut
);
  logic [WIDTH-1:0] bEff;
  logic [WIDTH:0]   full;
  logic [4:0]       nib;

  always_comb begin
    bEff     = opSub ? ~opB : opB;
    full     = {1'b0, opA} + {1'b0, bEff} + {{WIDTH{1'b0}}, opSub};
    nib      = {1'b0, opA[3:0]} + {1'b0, bEff[3:0]} + {4'b0, opSub};
    sum      = full[WIDTH-1:0];
    // borrow is the inverse of the adder carry when subtracting
    carryOut = full[WIDTH] ^ opSub;
    auxOut   = nib[4] ^ opSub;
    ovfOut   = (opA[WIDTH-1] == bEff[WIDTH-1]) && (full[WIDTH-1] != opA[WIDTH-1]);
  end
endmodule

// File: rtl/flagControl.sv
module flagControl
  import flagPkg::*;
(
  input  logic             wrEn,
  input  logic             loadEn,
  input  logic [CTL_N-1:0] ctlSet,
  input  logic [CTL_N-1:0] ctlClr,
  output strobeT           strobes
);
  always_comb begin
    strobes.loadAll   = loadEn;
    strobes.updStatus = wrEn & ~loadEn;
    strobes.setCtl    = ctlSet & {CTL_N{~loadEn}};
    strobes.clrCtl    = ctlClr & ~ctlSet & {CTL_N{~loadEn}};
  end
endmodule

// File: rtl/flagDatapath.sv
module flagDatapath
  import flagPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              opSub,
  input  logic              wordMode,
  input  logic [FLAG_W-1:0] loadValue,
  input  strobeT            strobes,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagsQ
);
  localparam int N_SIZES = 2;

  logic [DATA_W-1:0] sumArr [N_SIZES];
  logic [N_SIZES-1:0] carryArr, auxArr, ovfArr;

  for (genvar gi = 0; gi < N_SIZES; gi++) begin : gSize
    localparam int AW = (gi == 0) ? BYTE_W : DATA_W;
    logic [AW-1:0] sumW;
    flagAdder #(.WIDTH(AW)) uAdd (
      .opA(opA[AW-1:0]), .opB(opB[AW-1:0]), .opSub(opSub),
      .sum(sumW), .carryOut(carryArr[gi]), .auxOut(auxArr[gi]), .ovfOut(ovfArr[gi])
    );
    assign sumArr[gi] = DATA_W'(sumW);
  end

  logic              msbSel;
  logic [FLAG_W-1:0] statusWord;
  logic [CTL_N-1:0]  ctlNext;
  logic [FLAG_W-1:0] flagsD;

  always_comb begin
    result     = sumArr[wordMode];
    msbSel     = wordMode ? result[DATA_W-1] : result[BYTE_W-1];
    statusWord = '0;
    statusWord[CF_B] = carryArr[wordMode];
    statusWord[AF_B] = auxArr[wordMode];
    statusWord[OF_B] = ovfArr[wordMode];
    statusWord[SF_B] = msbSel;
    statusWord[ZF_B] = (result == '0);
    statusWord[PF_B] = ~^result[7:0];
  end

  for (genvar ci = 0; ci < CTL_N; ci++) begin : gCtl
    assign ctlNext[ci] = strobes.setCtl[ci] | (~strobes.clrCtl[ci] & flagsQ[CTL_BASE+ci]);
  end

  always_comb begin
    if (strobes.loadAll)
      flagsD = loadValue & USED_MASK;
    else
      flagsD = (strobes.updStatus ? statusWord : (flagsQ & STATUS_MASK))
             | (FLAG_W'(ctlNext) << CTL_BASE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= flagsD;
  end

  AST_LOAD_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAll |=> flagsQ == ($past(loadValue) & USED_MASK)); // R9
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ & ~USED_MASK) == '0); // R8
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadAll && strobes.setCtl == '0 && strobes.clrCtl == '0)
      |=> $stable(flagsQ & CTL_MASK)); // R11
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadAll && !strobes.updStatus) |=> $stable(flagsQ & STATUS_MASK)); // R11
  AST_ZERO_NOT_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    strobes.updStatus |=> !(flagsQ[ZF_B] && flagsQ[SF_B])); // R5
  AST_BYTE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !wordMode |-> result[DATA_W-1:BYTE_W] == '0); // R1
endmodule

// File: rtl/aluFlagUnit.sv
module aluFlagUnit
  import flagPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              opSub,
  input  logic              wordMode,
  input  logic              wrEn,
  input  logic              loadEn,
  input  logic [FLAG_W-1:0] loadValue,
  input  logic [CTL_N-1:0]  ctlSet,
  input  logic [CTL_N-1:0]  ctlClr,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);
  strobeT strobes;

  flagControl uCtl (
    .wrEn(wrEn), .loadEn(loadEn), .ctlSet(ctlSet), .ctlClr(ctlClr), .strobes(strobes)
  );

  flagDatapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) uDp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSub(opSub),
    .wordMode(wordMode), .loadValue(loadValue), .strobes(strobes),
    .result(result), .flagsQ(flags)
  );
endmodule

// File: tb/aluFlagUnit_bench.sv
module aluFlagUnit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0, opB = '0, loadValue = '0;
  logic        opSub = 1'b0, wordMode = 1'b0, wrEn = 1'b0, loadEn = 1'b0;
  logic [2:0]  ctlSet = '0, ctlClr = '0;
  logic [15:0] result, flags;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [15:0] shadow = '0;

  always #10 clk = ~clk;   // 50 MHz

  aluFlagUnit u_aluFlagUnit (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSub(opSub),
    .wordMode(wordMode), .wrEn(wrEn), .loadEn(loadEn), .loadValue(loadValue),
    .ctlSet(ctlSet), .ctlClr(ctlClr), .result(result), .flags(flags)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expResult(logic [15:0] a, logic [15:0] b, bit sub, bit word);
    int m = word ? 32'hFFFF : 32'hFF;
    int r = sub ? ((a & m) - (b & m)) : ((a & m) + (b & m));
    return 16'(r & m);
  endfunction

  function automatic logic [15:0] expStatus(logic [15:0] a, logic [15:0] b, bit sub, bit word);
    int n = word ? 16 : 8;
    int m = word ? 32'hFFFF : 32'hFF;
    int sa = a & m, sb = b & m, r;
    bit cf, af, of, sgn, aS, bS;
    logic [7:0] lo;
    logic [15:0] w = '0;
    if (!sub) begin
      r = sa + sb; cf = (r > m); af = ((sa & 15) + (sb & 15)) > 15;
    end else begin
      r = sa - sb; cf = (sa < sb); af = ((sa & 15) < (sb & 15));
    end
    r = r & m;
    sgn = r[n-1]; aS = sa[n-1]; bS = sb[n-1];
    of = sub ? ((aS != bS) && (sgn != aS)) : ((aS == bS) && (sgn != aS));
    lo = r[7:0];
    w[11] = of; w[7] = sgn; w[6] = (r == 0); w[4] = af;
    w[2] = ($countones(lo) % 2) == 0; w[0] = cf;
    return w;
  endfunction

  // one arithmetic operation with status update; checks result and flags
  task automatic doOp(string tag, logic [15:0] a, logic [15:0] b, bit sub, bit word);
    @(negedge clk);
    opA = a; opB = b; opSub = sub; wordMode = word; wrEn = 1'b1;
    #2 check({tag, " result"}, result, expResult(a, b, sub, word));
    @(negedge clk);
    wrEn = 1'b0;
    shadow = (shadow & 16'h0700) | expStatus(a, b, sub, word);
    check({tag, " flags"}, flags, shadow);
  endtask

  task automatic testReset();
    check("R8 reset flags", flags, 16'h0000);
    #2 check("R1 reset result", result, 16'h0000);
  endtask

  task automatic testSub();
    doOp("R2 53-42", 16'd53, 16'd42, 1'b1, 1'b0);
    check("R2 value 11", result, 16'd11);
    doOp("R3 borrow byte", 16'h0005, 16'h0007, 1'b1, 1'b0);
    check("R3 cf borrow", {15'b0, flags[0]}, 16'h0001);
    doOp("R3 borrow word", 16'h1000, 16'h2000, 1'b1, 1'b1);
  endtask

  task automatic testCarry();
    doOp("R3 byte wrap", 16'h00FF, 16'h0001, 1'b0, 1'b0);
    check("R5 zero set", {15'b0, flags[6]}, 16'h0001);
    check("R6 aux set", {15'b0, flags[4]}, 16'h0001);
    doOp("R3 word wrap", 16'hFFFF, 16'h0001, 1'b0, 1'b1);
  endtask

  task automatic testOverflow();
    doOp("R4 byte pos ovf", 16'h007F, 16'h0001, 1'b0, 1'b0);
    check("R4 of bit11", {15'b0, flags[11]}, 16'h0001);
    check("R5 sign bit7", {15'b0, flags[7]}, 16'h0001);
    doOp("R4 word sub ovf", 16'h8000, 16'h0001, 1'b1, 1'b1);
    doOp("R4 no ovf mixed", 16'h0080, 16'h0001, 1'b0, 1'b1);
  endtask

  task automatic testAux();
    doOp("R6 nibble borrow", 16'h0010, 16'h0001, 1'b1, 1'b0);
    check("R6 af borrow", {15'b0, flags[4]}, 16'h0001);
    doOp("R6 no nibble carry", 16'h0011, 16'h0022, 1'b0, 1'b0);
  endtask

  task automatic testParity();
    doOp("R7 even ones", 16'h0001, 16'h0002, 1'b0, 1'b0);
    check("R7 pf even", {15'b0, flags[2]}, 16'h0001);
    doOp("R7 odd ones", 16'h0003, 16'h0004, 1'b0, 1'b0);
    doOp("R7 word low byte only", 16'h0100, 16'h0000, 1'b0, 1'b1);
  endtask

  task automatic testWidth();
    doOp("R1 byte ignores high", 16'h12FF, 16'h3401, 1'b0, 1'b0);
    check("R1 byte high zero", result, 16'h0000);
    doOp("R1 word full", 16'h12FF, 16'h3401, 1'b0, 1'b1);
    check("R1 word value", result, 16'h4700);
    for (int i = 0; i < 8; i++) begin
      doOp("R1 sweep", 16'(i * 16'h2345 + 7), 16'(i * 16'h1F0B), bit'(i[0]), bit'(i[1]));
    end
  endtask

  task automatic testLoad();
    @(negedge clk);
    loadEn = 1'b1; loadValue = 16'hFFFF; wrEn = 1'b1; ctlClr = 3'b111;
    opA = 16'h0000; opB = 16'h0000;
    @(negedge clk);
    loadEn = 1'b0; wrEn = 1'b0; ctlClr = '0;
    shadow = 16'h0FD5;
    check("R9 load masked priority", flags, shadow);
    check("R8 unused zero", flags & 16'hF02A, 16'h0000);
  endtask

  task automatic testCtl();
    @(negedge clk);
    ctlClr = 3'b111;
    @(negedge clk);
    ctlClr = '0; shadow = shadow & ~16'h0700;
    check("R10 clear all ctl", flags, shadow);
    ctlSet = 3'b100;
    @(negedge clk);
    ctlSet = '0; shadow[10] = 1'b1;
    check("R10 set direction", flags, shadow);
    ctlSet = 3'b010; ctlClr = 3'b010;
    @(negedge clk);
    ctlSet = '0; ctlClr = '0; shadow[9] = 1'b1;
    check("R10 set wins", flags, shadow);
    ctlSet = 3'b001;
    @(negedge clk);
    ctlSet = '0; shadow[8] = 1'b1;
    ctlClr = 3'b100;
    @(negedge clk);
    ctlClr = '0; shadow[10] = 1'b0;
    check("R10 trap set dir clear", flags, shadow);
  endtask

  task automatic testHold();
    doOp("R11 arith keeps ctl", 16'h0080, 16'h0080, 1'b0, 1'b0);
    check("R11 ctl bits", flags & 16'h0700, 16'h0300);
    @(negedge clk);
    opA = 16'h0001; opB = 16'h0055; opSub = 1'b1; wordMode = 1'b1;
    @(negedge clk);
    check("R11 hold without wrEn", flags, shadow);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testSub();
    testCarry();
    testOverflow();
    testAux();
    testParity();
    testWidth();
    testLoad();
    testCtl();
    testHold();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule